// File: doc/BRIEF.md
# Staggered Per-Rank Refresh Scheduler

This block decides when each rank of a multi-rank DRAM controller must be refreshed. Every rank has its own down-counter. A round-robin pointer names the rank that is due next. At reset the counters start at evenly spaced values, so the deadlines of the ranks fall at equal steps across one refresh interval and never pile up on the same cycle. In each cycle only the counter under the pointer is tested. When it is at zero, the block pulses a request that names the rank, reloads that counter, marks the rank as waiting and moves the pointer to the next rank.

The command scheduler downstream watches `req_valid` and `req_rank`. It keeps refresh traffic ordered through the `refresh_waiting` flags. When it has actually issued the REFRESH command for a rank, it pulses `ack_valid` with that rank's index to clear the flag. All pins are plain control and status signals. A request is a one-cycle event that cannot be held off, so the interface has no ready signal and no back-pressure. The pending flag is what keeps a request that has not been served yet.

`N_RANKS` must be a power of two and `INTERVAL` at least `N_RANKS`. Elaboration stops on any other setting.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is held, `req_valid` is 0 and every `refresh_waiting` bit is 0. The pointer starts at rank 0, and rank i's counter starts at (INTERVAL / N_RANKS) * (i + 1). With S = INTERVAL / N_RANKS, the first request therefore names rank 0 and comes from the S-th clock edge after reset is released, counting that first edge as edge 0.
- R2: Requests name the ranks in strict rotation 0, 1, ..., N_RANKS-1, 0, ... . Only the rank under the pointer can ever raise a request.
- R3: `req_valid` is registered. It is high for exactly the one cycle after the edge at which the selected counter was found at zero, and `req_rank` carries that rank's index during that cycle.
- R4: When a rank's counter is tested and found at zero, it is reloaded with INTERVAL and decremented in the same cycle. Its next request therefore comes exactly INTERVAL cycles after the previous one.
- R5: The `refresh_waiting` bit of a rank becomes 1 in the same cycle as that rank's request. It stays 1 until an acknowledge for that rank arrives. A bit never rises without a request for its rank.
- R6: `ack_valid` with `ack_rank` = r clears bit r of `refresh_waiting` from the next cycle on. The bits of the other ranks do not change. An acknowledge for a rank that is not waiting has no effect.
- R7: If an acknowledge for rank r is sampled on the same edge as a new request for rank r, the new request wins and bit r stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ack_valid | input | 1 | Refresh for `ack_rank` has been issued |
| ack_rank | input | max(1, log2(N_RANKS)) | Rank whose refresh was issued |
| req_valid | output | 1 | One-cycle refresh request pulse |
| req_rank | output | max(1, log2(N_RANKS)) | Rank named by the request |
| refresh_waiting | output | N_RANKS | Per-rank refresh-waiting flags |

## Verification
Setting a rank's waiting flag (from its counter expiring) and clearing it (from an acknowledge) can fall on the same clock edge for the same rank. The bench provokes this by timing an acknowledge for rank 1 to land on the exact edges where rank 1's counter reaches zero. It then judges that the flag is still 1 in the cycle that carries the new request. Acknowledges on other edges are spread across all ranks, including ranks that are not waiting, so that both the clearing path and the no-effect path meet the reference model.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  // Index width for a rank count; at least one bit.
  function automatic int rank_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Counter width able to hold the full interval.
  function automatic int count_w(input int interval);
    return $clog2(interval + 1);
  endfunction
endpackage

// File: rtl/refresh_rank_timer.sv
module refresh_rank_timer #(
  parameter int INTERVAL = 64,
  parameter int INIT     = 16,
  parameter int CW       = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic expired
);
  localparam logic [CW-1:0] INIT_V   = CW'(INIT);
  localparam logic [CW-1:0] RELOAD_V = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  // Reload and the per-cycle decrement happen together; otherwise saturate at zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= INIT_V;
    else if (reload)         cnt_q <= RELOAD_V;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/refresh_rr_pointer.sv
module refresh_rr_pointer #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [PW-1:0] sel
);
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel <= '0;
    else if (advance)  sel <= (sel == LAST) ? '0 : sel + PW'(1);
  end
endmodule

// File: rtl/refresh_wait_flags.sv
module refresh_wait_flags #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [PW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [PW-1:0] clr_idx,
  output logic [N-1:0]  flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // A new request outranks an acknowledge for the same rank.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              flags[i] <= 1'b0;
      else if (set_en && set_idx == PW'(i))    flags[i] <= 1'b1;
      else if (clr_en && clr_idx == PW'(i))    flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
  parameter int N_RANKS  = 4,
  parameter int INTERVAL = 64,
  localparam int RW = refresh_sched_pkg::rank_w(N_RANKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_valid,
  input  logic [RW-1:0]      ack_rank,
  output logic               req_valid,
  output logic [RW-1:0]      req_rank,
  output logic [N_RANKS-1:0] refresh_waiting
);
  localparam int CW      = refresh_sched_pkg::count_w(INTERVAL);
  localparam int STAGGER = INTERVAL / N_RANKS;

  if ((N_RANKS & (N_RANKS - 1)) != 0 || INTERVAL < N_RANKS) begin : g_bad_cfg
    $error("refresh_scheduler: N_RANKS must be a power of two and INTERVAL >= N_RANKS");
  end

  logic [N_RANKS-1:0] expired_vec;
  logic [N_RANKS-1:0] reload_vec;
  logic [RW-1:0]      sel;
  logic               hit;

  assign hit = expired_vec[sel];

  for (genvar i = 0; i < N_RANKS; i++) begin : g_rank
    assign reload_vec[i] = hit && (sel == RW'(i));
    refresh_rank_timer #(
      .INTERVAL(INTERVAL),
      .INIT    (STAGGER * (i + 1)),
      .CW      (CW)
    ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (reload_vec[i]),
      .expired(expired_vec[i])
    );
  end

  refresh_rr_pointer #(.N(N_RANKS), .PW(RW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .advance(hit),
    .sel    (sel)
  );

  refresh_wait_flags #(.N(N_RANKS), .PW(RW)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (hit),
    .set_idx(sel),
    .clr_en (ack_valid),
    .clr_idx(ack_rank),
    .flags  (refresh_waiting)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_rank  <= '0;
    end else begin
      req_valid <= hit;
      req_rank  <= sel;
    end
  end
endmodule

// File: rtl/refresh_sched_checker.sv
module refresh_sched_checker #(
  parameter int N_RANKS  = 4,
  parameter int INTERVAL = 64,
  parameter int RW       = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack_valid,
  input logic [RW-1:0]      ack_rank,
  input logic               req_valid,
  input logic [RW-1:0]      req_rank,
  input logic [N_RANKS-1:0] refresh_waiting
);
  localparam int STAGGER = INTERVAL / N_RANKS;
  localparam logic [RW-1:0] LAST = RW'(N_RANKS - 1);

  int unsigned   since_q;
  int unsigned   gap0_q;
  logic          seen_q;
  logic          seen0_q;
  logic [RW-1:0] last_q;
  logic [RW-1:0] next_exp;

  assign next_exp = (last_q == LAST) ? '0 : last_q + RW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= 0;
      gap0_q  <= 0;
      seen_q  <= 1'b0;
      seen0_q <= 1'b0;
      last_q  <= '0;
    end else begin
      if (since_q < 32'h7fff_ffff) since_q <= since_q + 1;
      if (req_valid) begin
        seen_q <= 1'b1;
        last_q <= req_rank;
      end
      if (req_valid && req_rank == '0) begin
        seen0_q <= 1'b1;
        gap0_q  <= 1;
      end else if (gap0_q < 32'h7fff_ffff) begin
        gap0_q <= gap0_q + 1;
      end
    end
  end

  a_r1_first_due: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !seen_q) |-> (req_rank == '0 && since_q == STAGGER + 1));

  a_r2_rank_order: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seen_q) |-> (req_rank == next_exp));

  a_r4_same_rank_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_rank == '0 && seen0_q) |-> (gap0_q == INTERVAL));

  a_r5_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> refresh_waiting[req_rank]);

  for (genvar i = 0; i < N_RANKS; i++) begin : g_rise
    a_r5_rise_only_on_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(refresh_waiting[i]) |-> (req_valid && req_rank == RW'(i)));
  end

  // R6 and R7: acknowledge clears unless a request for that rank landed on the same edge.
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> (!refresh_waiting[$past(ack_rank)] ||
                   (req_valid && req_rank == $past(ack_rank))));
endmodule

bind refresh_scheduler refresh_sched_checker #(
  .N_RANKS (N_RANKS),
  .INTERVAL(INTERVAL),
  .RW      (RW)
) u_refresh_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ack_valid      (ack_valid),
  .ack_rank       (ack_rank),
  .req_valid      (req_valid),
  .req_rank       (req_rank),
  .refresh_waiting(refresh_waiting)
);

// File: tb/refresh_scheduler_test.sv
`timescale 1ns/1ps
module refresh_scheduler_test;
  localparam int N  = 4;
  localparam int IV = 64;
  localparam int S  = IV / N;
  localparam int RW = refresh_sched_pkg::rank_w(N);
  localparam int RUN = 5 * IV + 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ack_valid = 1'b0;
  logic [RW-1:0] ack_rank = '0;
  logic          req_valid;
  logic [RW-1:0] req_rank;
  logic [N-1:0]  refresh_waiting;

  always #2.5 clk = ~clk;

  refresh_scheduler #(.N_RANKS(N), .INTERVAL(IV)) uut (
    .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_rank(ack_rank),
    .req_valid(req_valid), .req_rank(req_rank), .refresh_waiting(refresh_waiting)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Reference state
  int m_cnt[N];
  bit m_wait[N];
  int m_ptr;
  bit m_valid;
  int m_rank;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_cnt[i]  = S * (i + 1);
      m_wait[i] = 1'b0;
    end
    m_ptr = 0; m_valid = 1'b0; m_rank = 0;
  endtask

  task automatic model_step(input bit av, input int ar);
    bit hit;
    hit = (m_cnt[m_ptr] == 0);
    for (int i = 0; i < N; i++) begin
      if (hit && i == m_ptr) m_cnt[i] = IV - 1;
      else if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
    end
    if (av) m_wait[ar] = 1'b0;
    if (hit) m_wait[m_ptr] = 1'b1;
    m_valid = hit;
    m_rank  = m_ptr;
    if (hit) m_ptr = (m_ptr + 1) % N;
  endtask

  function automatic int wait_vec();
    int v = 0;
    for (int i = 0; i < N; i++) if (m_wait[i]) v |= (1 << i);
    return v;
  endfunction

  initial begin
    int first_edge = -1;
    int last0 = -1;
    int order_exp = 0;
    bit av;
    int ar;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_valid == 1'b0, "R1 reset req_valid", int'(req_valid), 0);
    check(refresh_waiting == '0, "R1 reset waiting", int'(refresh_waiting), 0);
    rst_n = 1'b1;
    for (int e = 0; e < RUN; e++) begin
      av = 1'b0; ar = 0;
      if (N > 1 && e >= 2 * S && ((e - 2 * S) % IV) == 0) begin
        av = 1'b1; ar = 1;             // lands on rank 1's due edge (R7)
      end else if ((e % 5) == 3) begin
        av = 1'b1; ar = (e / 5) % N;   // spread acks, some to idle ranks (R6)
      end
      ack_valid = av;
      ack_rank  = RW'(ar);
      @(negedge clk);
      model_step(av, ar);
      check(req_valid == m_valid, "R3 req_valid", int'(req_valid), int'(m_valid));
      if (m_valid)
        check(int'(req_rank) == m_rank, "R2 req_rank", int'(req_rank), m_rank);
      check(int'(refresh_waiting) == wait_vec(), "R5/R6 waiting", int'(refresh_waiting), wait_vec());
      if (req_valid) begin
        if (first_edge < 0) begin
          first_edge = e;
          check(e == S && req_rank == '0, "R1 first due edge", e, S);
        end
        check(int'(req_rank) == order_exp, "R2 rotation", int'(req_rank), order_exp);
        order_exp = (order_exp + 1) % N;
        if (req_rank == '0) begin
          if (last0 >= 0) check(e - last0 == IV, "R4 spacing", e - last0, IV);
          last0 = e;
        end
      end
      if (av && ar == 1 && N > 1 && e >= 2 * S && ((e - 2 * S) % IV) == 0) begin
        check(req_valid && int'(req_rank) == 1, "R7 collision req", int'(req_rank), 1);
        check(refresh_waiting[1] == 1'b1, "R7 set wins", int'(refresh_waiting[1]), 1);
      end
    end
    ack_valid = 1'b0;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R3 watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule